// File: doc/BRIEF.md
# Load Queue with Store-Ordering Violation Detection

This block tracks in-flight loads of an out-of-order core in a circular buffer. Each load takes a slot in program order and carries its sequence number. When the load executes, its effective address is recorded in that slot. Before that happens the slot holds no address and cannot take part in any comparison.

When a store executes, the queue looks for loads that are younger than the store, have already executed, and fall in the same 256-byte block as the store. Such a load read memory too early. The oldest such load is latched as the pending violator and announced with a one-cycle pulse. The report stays in place until the consumer reads it, and stores that execute in the meantime are not searched.

The queue retires loads from its old end against a commit bound and discards loads from its young end against a squash bound. It also reports how many more memory operations may be allocated, taking the free space of a companion store queue into account.

Top module: `lq_order_q`

## Requirements
- R1: An accepted allocation (`alloc_vld` high while `alloc_ok` is high) writes the load into the slot shown on `alloc_idx`, which is the slot after the youngest load, wrapping modulo DEPTH. `lq_count` rises by one at the next clock edge.
- R2: `free_cnt` equals min(DEPTH − `lq_count`, `sq_free`) − 1, floored at zero. `full` is high exactly when `free_cnt` is zero. While `full` is high, `alloc_ok` is low and an allocation request leaves `lq_count` unchanged.
- R3: A load that has not executed since it was allocated never matches a store.
- R4: A store with sequence number S and address A matches an executed load with sequence number L and address B only if L > S and B[ADDR_W-1:8] equals A[ADDR_W-1:8]. Loads with L ≤ S and loads in another 256-byte block are never reported.
- R5: When several loads match, the oldest of them (the one closest to the commit end) is reported.
- R6: The clock edge that samples a matching store raises `viol_pulse` for exactly one cycle, sets `viol_pend`, and loads `viol_seq`/`viol_idx` with the load's sequence number and slot. These values stay unchanged while `viol_pend` is high.
- R7: While `viol_pend` is high, executing stores perform no search and the held report does not change. Asserting `viol_rd` clears `viol_pend` at the next edge.
- R8: A commit with bound C removes loads from the oldest end while their sequence number is ≤ C. It stops at the first load above C.
- R9: A squash with bound Q removes every load whose sequence number is greater than Q, counting from the youngest end. In a squash cycle, allocation and commit requests are ignored, and `alloc_ok` is low.
- R10: After reset, `lq_count` is 0, `viol_pend` and `viol_pulse` are 0, and `free_cnt` is min(DEPTH, `sq_free`) − 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| alloc_vld | input | 1 | Request to allocate a load |
| alloc_seq | input | SEQ_W | Sequence number of the allocated load |
| alloc_ok | output | 1 | Allocation would be accepted this cycle |
| alloc_idx | output | IDX_W | Slot the next allocation uses |
| exec_vld | input | 1 | A load has executed |
| exec_idx | input | IDX_W | Slot of the executed load |
| exec_addr | input | ADDR_W | Effective address of the executed load |
| st_vld | input | 1 | A store has executed; search younger loads |
| st_seq | input | SEQ_W | Sequence number of the store |
| st_addr | input | ADDR_W | Effective address of the store |
| viol_rd | input | 1 | Consume the pending violation report |
| viol_pulse | output | 1 | One-cycle strobe for a new violation |
| viol_pend | output | 1 | A violation report is held |
| viol_seq | output | SEQ_W | Sequence number of the offending load |
| viol_idx | output | IDX_W | Slot of the offending load |
| cmt_vld | input | 1 | Commit request |
| cmt_bound | input | SEQ_W | Youngest sequence number allowed to commit |
| sqh_vld | input | 1 | Squash request |
| sqh_bound | input | SEQ_W | Loads above this sequence number are squashed |
| sq_free | input | SQ_CW | Free slots in the companion store queue |
| free_cnt | output | CNT_W | Allocatable slots remaining |
| full | output | 1 | No allocation possible |
| lq_count | output | CNT_W | Loads currently held |

## Verification
Some properties are checked on every cycle. Occupancy never passes DEPTH−1, and it cannot grow while `full` is high or during a squash. A violation strobe always comes from a store sampled while no report was pending, and a pending report keeps its sequence number and slot until it is read. Other behaviour depends on the sequence numbers, address blocks and execution state of specific loads, so only the directed scenarios can show it. This covers which load is chosen as oldest, older-store and other-block exclusion, unexecuted loads being skipped, commit stopping at the bound, squash trimming from the young end, and slot reuse after wrap-around.

// File: rtl/lq_order_pkg.sv
// Shared types for the load queue.
// Assumes nothing beyond being compiled before the modules that import it.
package lq_order_pkg;

    // Which end of the ring a trimming scan starts from.
    typedef enum logic {
        TRIM_OLDEST   = 1'b0,
        TRIM_YOUNGEST = 1'b1
    } trim_dir_e;

endpackage

// File: rtl/lq_trim.sv
// Counts how many consecutive loads, scanned from one end of the ring,
// satisfy the trimming condition against a bound. Scanning from the
// oldest end, the condition is seq <= bound (commit). Scanning from the
// youngest end, it is seq > bound (squash).
// Assumes DEPTH is a power of two, so slot arithmetic wraps naturally.
module lq_trim
    import lq_order_pkg::*;
#(
    parameter int        DEPTH = 8,
    parameter int        SEQ_W = 16,
    parameter trim_dir_e DIR   = TRIM_OLDEST,
    localparam int       IDX_W = $clog2(DEPTH),
    localparam int       CNT_W = $clog2(DEPTH + 1)
) (
    input  logic [SEQ_W-1:0] seq_q [DEPTH],
    input  logic [IDX_W-1:0] head,
    input  logic [CNT_W-1:0] count,
    input  logic [SEQ_W-1:0] bound,
    output logic [CNT_W-1:0] run
);

    logic [DEPTH-1:0] hit_ord;

    for (genvar k = 0; k < DEPTH; k++) begin : g_scan
        logic [IDX_W-1:0] slot;
        logic             live;
        assign live = CNT_W'(k) < count;
        if (DIR == TRIM_OLDEST) begin : g_old
            assign slot       = head + IDX_W'(k);
            assign hit_ord[k] = live && (seq_q[slot] <= bound);
        end else begin : g_young
            assign slot       = head + IDX_W'(count) - IDX_W'(1) - IDX_W'(k);
            assign hit_ord[k] = live && (seq_q[slot] > bound);
        end
    end

    // Length of the unbroken run of qualifying loads from the scan start.
    always_comb begin
        logic stop;
        run  = '0;
        stop = 1'b0;
        for (int k = 0; k < DEPTH; k++) begin
            if (!stop) begin
                if (hit_ord[k]) run = run + CNT_W'(1);
                else            stop = 1'b1;
            end
        end
    end

endmodule

// File: rtl/lq_match.sv
// Store-to-load ordering search: finds the oldest executed load that is
// younger than the store and whose address block tag equals the store's.
// Assumes DEPTH is a power of two and tags are pre-shifted by the caller.
module lq_match #(
    parameter int  DEPTH = 8,
    parameter int  SEQ_W = 16,
    parameter int  TAG_W = 24,
    localparam int IDX_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic [SEQ_W-1:0] seq_q [DEPTH],
    input  logic [TAG_W-1:0] tag_q [DEPTH],
    input  logic [DEPTH-1:0] done_q,
    input  logic [IDX_W-1:0] head,
    input  logic [CNT_W-1:0] count,
    input  logic [SEQ_W-1:0] st_seq,
    input  logic [TAG_W-1:0] st_tag,
    output logic             hit,
    output logic [IDX_W-1:0] hit_idx
);

    logic [DEPTH-1:0] cand;

    for (genvar k = 0; k < DEPTH; k++) begin : g_cmp
        logic [IDX_W-1:0] slot;
        assign slot    = head + IDX_W'(k);
        assign cand[k] = (CNT_W'(k) < count) && done_q[slot]
                         && (seq_q[slot] > st_seq) && (tag_q[slot] == st_tag);
    end

    // Priority pick: the lowest age offset wins, so the oldest match is reported.
    always_comb begin
        hit     = 1'b0;
        hit_idx = head;
        for (int k = DEPTH - 1; k >= 0; k--) begin
            if (cand[k]) begin
                hit     = 1'b1;
                hit_idx = head + IDX_W'(k);
            end
        end
    end

endmodule

// File: rtl/lq_order_q.sv
// Load queue ring. Allocates loads in program order, records executed
// addresses, flags the oldest younger load hit by an executing store
// (256-byte granularity by default), commits from the old end and
// squashes from the young end.
// Assumes DEPTH is a power of two and that sequence numbers increase in
// program order without wrapping. A store is compared against the queue
// contents as they stand before the edge that samples it.
module lq_order_q
    import lq_order_pkg::*;
#(
    parameter int  DEPTH    = 8,
    parameter int  SEQ_W    = 16,
    parameter int  ADDR_W   = 32,
    parameter int  GRAN_SH  = 8,
    parameter int  SQ_DEPTH = 16,
    localparam int IDX_W    = $clog2(DEPTH),
    localparam int CNT_W    = $clog2(DEPTH + 1),
    localparam int SQ_CW    = $clog2(SQ_DEPTH + 1),
    localparam int TAG_W    = ADDR_W - GRAN_SH
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              alloc_vld,
    input  logic [SEQ_W-1:0]  alloc_seq,
    output logic              alloc_ok,
    output logic [IDX_W-1:0]  alloc_idx,
    input  logic              exec_vld,
    input  logic [IDX_W-1:0]  exec_idx,
    input  logic [ADDR_W-1:0] exec_addr,
    input  logic              st_vld,
    input  logic [SEQ_W-1:0]  st_seq,
    input  logic [ADDR_W-1:0] st_addr,
    input  logic              viol_rd,
    output logic              viol_pulse,
    output logic              viol_pend,
    output logic [SEQ_W-1:0]  viol_seq,
    output logic [IDX_W-1:0]  viol_idx,
    input  logic              cmt_vld,
    input  logic [SEQ_W-1:0]  cmt_bound,
    input  logic              sqh_vld,
    input  logic [SEQ_W-1:0]  sqh_bound,
    input  logic [SQ_CW-1:0]  sq_free,
    output logic [CNT_W-1:0]  free_cnt,
    output logic              full,
    output logic [CNT_W-1:0]  lq_count
);

    logic [SEQ_W-1:0] seq_q [DEPTH];
    logic [TAG_W-1:0] tag_q [DEPTH];
    logic [DEPTH-1:0] done_q;
    logic [IDX_W-1:0] head;
    logic [CNT_W-1:0] count;
    logic [IDX_W-1:0] tail;
    logic [CNT_W-1:0] cm_run, sq_run, cm_take;
    logic             alloc_fire, exec_ok, m_hit;
    logic [IDX_W-1:0] m_idx, exec_off;
    logic             unused_low;

    assign unused_low = ^{exec_addr[GRAN_SH-1:0], st_addr[GRAN_SH-1:0]};

    // Free-slot arithmetic: the smaller free space minus the reserved slot.
    always_comb begin
        int room, lim;
        room     = DEPTH - int'(count);
        lim      = (room < int'(sq_free)) ? room : int'(sq_free);
        free_cnt = (lim > 0) ? CNT_W'(lim - 1) : '0;
    end

    assign full       = (free_cnt == '0);
    assign tail       = head + IDX_W'(count);
    assign alloc_idx  = tail;
    assign alloc_ok   = !full && !sqh_vld;
    assign alloc_fire = alloc_vld && alloc_ok;
    assign cm_take    = (cmt_vld && !sqh_vld) ? cm_run : '0;
    assign exec_off   = exec_idx - head;
    assign exec_ok    = exec_vld && (CNT_W'(exec_off) < count);
    assign lq_count   = count;

    lq_trim #(.DEPTH(DEPTH), .SEQ_W(SEQ_W), .DIR(TRIM_OLDEST)) u_cmt (
        .seq_q(seq_q), .head(head), .count(count), .bound(cmt_bound), .run(cm_run)
    );

    lq_trim #(.DEPTH(DEPTH), .SEQ_W(SEQ_W), .DIR(TRIM_YOUNGEST)) u_sqh (
        .seq_q(seq_q), .head(head), .count(count), .bound(sqh_bound), .run(sq_run)
    );

    lq_match #(.DEPTH(DEPTH), .SEQ_W(SEQ_W), .TAG_W(TAG_W)) u_match (
        .seq_q(seq_q), .tag_q(tag_q), .done_q(done_q), .head(head), .count(count),
        .st_seq(st_seq), .st_tag(st_addr[ADDR_W-1:GRAN_SH]),
        .hit(m_hit), .hit_idx(m_idx)
    );

    // Ring pointer and occupancy: squash wins, otherwise commit and allocate.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            head  <= '0;
            count <= '0;
        end else if (sqh_vld) begin
            count <= count - sq_run;
        end else begin
            head  <= head + IDX_W'(cm_take);
            count <= count - cm_take + CNT_W'(alloc_fire);
        end
    end

    // Per-slot payload: sequence number on allocation, block tag on execution.
    always_ff @(posedge clk) begin
        if (alloc_fire) seq_q[tail] <= alloc_seq;
        if (exec_ok)    tag_q[exec_idx] <= exec_addr[ADDR_W-1:GRAN_SH];
    end

    // Executed flags: cleared on allocation, set when the address arrives.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_q <= '0;
        end else begin
            if (alloc_fire) done_q[tail] <= 1'b0;
            if (exec_ok)    done_q[exec_idx] <= 1'b1;
        end
    end

    // Violation report: latch the first hit, hold it until it is read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            viol_pulse <= 1'b0;
            viol_pend  <= 1'b0;
            viol_seq   <= '0;
            viol_idx   <= '0;
        end else begin
            viol_pulse <= 1'b0;
            if (!viol_pend && st_vld && m_hit) begin
                viol_pulse <= 1'b1;
                viol_pend  <= 1'b1;
                viol_seq   <= seq_q[m_idx];
                viol_idx   <= m_idx;
            end else if (viol_rd) begin
                viol_pend  <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/lq_order_q_chk.sv
// Cycle-level properties of the load queue, bound to every instance.
// Assumes the reset is synchronous and active-low.
module lq_order_q_chk #(
    parameter int DEPTH = 8,
    parameter int SEQ_W = 16,
    parameter int IDX_W = 3,
    parameter int CNT_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             full,
    input logic             sqh_vld,
    input logic             st_vld,
    input logic             viol_rd,
    input logic             viol_pulse,
    input logic             viol_pend,
    input logic [SEQ_W-1:0] viol_seq,
    input logic [IDX_W-1:0] viol_idx,
    input logic [CNT_W-1:0] lq_count
);

    // R2
    count_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lq_count <= CNT_W'(DEPTH - 1));

    // R2
    full_no_grow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        full |=> lq_count <= $past(lq_count));

    // R9
    squash_no_grow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sqh_vld |=> lq_count <= $past(lq_count));

    // R6
    pulse_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
        viol_pulse |-> viol_pend);

    // R7
    pulse_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        viol_pulse |-> ($past(st_vld) && !$past(viol_pend)));

    // R6
    report_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (viol_pend && !viol_rd) |=> (viol_pend && $stable(viol_seq) && $stable(viol_idx)));

endmodule

bind lq_order_q lq_order_q_chk #(
    .DEPTH(DEPTH), .SEQ_W(SEQ_W), .IDX_W(IDX_W), .CNT_W(CNT_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .full(full), .sqh_vld(sqh_vld), .st_vld(st_vld),
    .viol_rd(viol_rd), .viol_pulse(viol_pulse), .viol_pend(viol_pend),
    .viol_seq(viol_seq), .viol_idx(viol_idx), .lq_count(lq_count)
);

// File: tb/tb_lq_order_q.sv
// Directed bench for lq_order_q: one task per scenario, each self-checking.
module tb_lq_order_q;

    localparam int DEPTH = 8;
    localparam int SEQ_W = 16;
    localparam int ADDR_W = 32;
    localparam int IDX_W = 3;
    localparam int CNT_W = 4;
    localparam int SQ_CW = 5;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              alloc_vld = 1'b0;
    logic [SEQ_W-1:0]  alloc_seq = '0;
    logic              alloc_ok;
    logic [IDX_W-1:0]  alloc_idx;
    logic              exec_vld = 1'b0;
    logic [IDX_W-1:0]  exec_idx = '0;
    logic [ADDR_W-1:0] exec_addr = '0;
    logic              st_vld = 1'b0;
    logic [SEQ_W-1:0]  st_seq = '0;
    logic [ADDR_W-1:0] st_addr = '0;
    logic              viol_rd = 1'b0;
    logic              viol_pulse, viol_pend;
    logic [SEQ_W-1:0]  viol_seq;
    logic [IDX_W-1:0]  viol_idx;
    logic              cmt_vld = 1'b0;
    logic [SEQ_W-1:0]  cmt_bound = '0;
    logic              sqh_vld = 1'b0;
    logic [SEQ_W-1:0]  sqh_bound = '0;
    logic [SQ_CW-1:0]  sq_free = 5'd12;
    logic [CNT_W-1:0]  free_cnt;
    logic              full;
    logic [CNT_W-1:0]  lq_count;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    lq_order_q dut (
        .clk(clk), .rst_n(rst_n),
        .alloc_vld(alloc_vld), .alloc_seq(alloc_seq), .alloc_ok(alloc_ok), .alloc_idx(alloc_idx),
        .exec_vld(exec_vld), .exec_idx(exec_idx), .exec_addr(exec_addr),
        .st_vld(st_vld), .st_seq(st_seq), .st_addr(st_addr),
        .viol_rd(viol_rd), .viol_pulse(viol_pulse), .viol_pend(viol_pend),
        .viol_seq(viol_seq), .viol_idx(viol_idx),
        .cmt_vld(cmt_vld), .cmt_bound(cmt_bound),
        .sqh_vld(sqh_vld), .sqh_bound(sqh_bound),
        .sq_free(sq_free), .free_cnt(free_cnt), .full(full), .lq_count(lq_count)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic report();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    endtask

    // Allocation: sample acceptance and slot before the capturing edge.
    task automatic do_alloc(input int s, input bit exp_ok, input int exp_idx, input string req);
        @(negedge clk);
        alloc_vld = 1'b1; alloc_seq = SEQ_W'(s);
        #1;
        chk({req, " alloc_ok"}, int'(alloc_ok), int'(exp_ok));
        if (exp_ok) chk({req, " alloc_idx"}, int'(alloc_idx), exp_idx);
        @(negedge clk);
        alloc_vld = 1'b0;
    endtask

    task automatic do_exec(input int idx, input int addr);
        @(negedge clk);
        exec_vld = 1'b1; exec_idx = IDX_W'(idx); exec_addr = ADDR_W'(addr);
        @(negedge clk);
        exec_vld = 1'b0;
    endtask

    // Store: the report is visible half a cycle after the sampling edge.
    task automatic do_store(input int s, input int addr);
        @(negedge clk);
        st_vld = 1'b1; st_seq = SEQ_W'(s); st_addr = ADDR_W'(addr);
        @(negedge clk);
        st_vld = 1'b0;
    endtask

    task automatic do_read();
        @(negedge clk);
        viol_rd = 1'b1;
        @(negedge clk);
        viol_rd = 1'b0;
    endtask

    task automatic do_commit(input int b);
        @(negedge clk);
        cmt_vld = 1'b1; cmt_bound = SEQ_W'(b);
        @(negedge clk);
        cmt_vld = 1'b0;
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R10 count", int'(lq_count), 0);
        chk("R10 pend", int'(viol_pend), 0);
        chk("R10 pulse", int'(viol_pulse), 0);
        chk("R10 free", int'(free_cnt), 7);
    endtask

    task automatic t_alloc_and_full();
        do_alloc(10, 1'b1, 0, "R1");
        do_alloc(20, 1'b1, 1, "R1");
        do_alloc(30, 1'b1, 2, "R1");
        do_alloc(40, 1'b1, 3, "R1");
        chk("R1 count", int'(lq_count), 4);
        chk("R2 free lq-limited", int'(free_cnt), 3);
        sq_free = 5'd2; #1;
        chk("R2 free sq-limited", int'(free_cnt), 1);
        sq_free = 5'd1; #1;
        chk("R2 free zero", int'(free_cnt), 0);
        chk("R2 full", int'(full), 1);
        do_alloc(45, 1'b0, 0, "R2");
        chk("R2 refused count", int'(lq_count), 4);
        sq_free = 5'd12; #1;
        chk("R2 full cleared", int'(full), 0);
    endtask

    task automatic t_violation();
        do_exec(1, 'h1234);
        do_exec(3, 'h12FF);
        // Slot 2 (seq 30) stays unexecuted.
        do_store(45, 'h1210);
        chk("R4 older loads skipped", int'(viol_pulse), 0);
        chk("R4 older loads pend", int'(viol_pend), 0);
        do_store(25, 'h1300);
        chk("R4 other block", int'(viol_pend), 0);
        do_store(25, 'h1280);
        chk("R6 pulse", int'(viol_pulse), 1);
        chk("R3 unexecuted skipped seq", int'(viol_seq), 40);
        chk("R6 idx", int'(viol_idx), 3);
        @(negedge clk);
        chk("R6 pulse one cycle", int'(viol_pulse), 0);
        chk("R6 pend held", int'(viol_pend), 1);
        do_store(15, 'h1200);
        chk("R7 no new pulse", int'(viol_pulse), 0);
        chk("R7 report kept", int'(viol_seq), 40);
        do_read();
        chk("R7 read clears", int'(viol_pend), 0);
        do_store(15, 'h1200);
        chk("R5 oldest seq", int'(viol_seq), 20);
        chk("R5 oldest idx", int'(viol_idx), 1);
        do_read();
        chk("R7 read clears again", int'(viol_pend), 0);
    endtask

    task automatic t_commit();
        do_commit(25);
        chk("R8 commit to 25", int'(lq_count), 2);
        do_commit(5);
        chk("R8 nothing below", int'(lq_count), 2);
        do_commit(30);
        chk("R8 bound inclusive", int'(lq_count), 1);
        do_alloc(50, 1'b1, 4, "R8 head moved");
    endtask

    task automatic t_squash_wrap();
        do_alloc(60, 1'b1, 5, "R1");
        do_alloc(70, 1'b1, 6, "R1");
        chk("R1 count before squash", int'(lq_count), 4);
        @(negedge clk);
        sqh_vld = 1'b1; sqh_bound = 16'd55;
        alloc_vld = 1'b1; alloc_seq = 16'd80;
        cmt_vld = 1'b1; cmt_bound = 16'd100;
        #1;
        chk("R9 alloc_ok low", int'(alloc_ok), 0);
        @(negedge clk);
        sqh_vld = 1'b0; alloc_vld = 1'b0; cmt_vld = 1'b0;
        chk("R9 squash count", int'(lq_count), 2);
        do_alloc(90, 1'b1, 5, "R9 tail reused");
        do_alloc(100, 1'b1, 6, "R1");
        do_alloc(110, 1'b1, 7, "R1");
        do_alloc(120, 1'b1, 0, "R1 wrap");
        chk("R2 free near full", int'(free_cnt), 1);
        do_alloc(130, 1'b1, 1, "R1");
        chk("R2 full at DEPTH-1", int'(full), 1);
        do_alloc(140, 1'b0, 0, "R2");
        chk("R2 count capped", int'(lq_count), 7);
        @(negedge clk);
        sqh_vld = 1'b1; sqh_bound = 16'd0;
        @(negedge clk);
        sqh_vld = 1'b0;
        chk("R9 squash all", int'(lq_count), 0);
        chk("R9 free restored", int'(free_cnt), 7);
    endtask

    initial begin
        t_reset();
        t_alloc_and_full();
        t_violation();
        t_commit();
        t_squash_wrap();
        done = 1'b1;
        report();
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            report();
            $finish;
        end
    end

endmodule